// File: doc/BRIEF.md
# Interval-Based Logic BIST Sequencer

This block runs a gate-level self-test of a processor core as a segment of numbered test intervals. Firmware sets how many intervals one invocation covers, whether the run starts again at interval 0 or resumes at the stored continuation point, a divider for the test clock and a timeout value. Firmware then writes an enable key. While the run is active the host is stalled. The sequencer issues each interval to an interval engine with a start/done handshake and compares the returned signature against the expected one. When the run ends it records done, fail and timeout status and raises a CPU reset request. The request is raised on every completion, whatever the outcome.

The per-interval engine (pattern generation, microcode and signature compaction) is a stub in this project. It takes a fixed number of divided test-clock ticks per interval and returns a signature computed from the interval index. A fault hook lets one chosen interval return a corrupted signature. The status flags and the current-interval counter live only in the sequencer, so they survive the CPU reset that the sequencer requests and firmware can read the verdict afterwards.

Top module: `lbist_seq`

## Requirements
- R1: After reset, `stall` and `cpu_rst_req` are 0, all three status flags are 0 and `cur_interval` is 0.
- R2: A run starts only when `key_we` is high in an idle cycle with `key_val` equal to 4'hA. Any other key value has no effect: stall stays low, no reset request is raised and `cur_interval` is unchanged. Key writes made during a run are ignored.
- R3: A divide setting `cfg_div` of 0 (divide by 1) is invalid, and a correct key written with it does not start a run.
- R4: `stall` rises in the cycle after an accepted key write. It stays high until the run's final cycle, the one in which `cpu_rst_req` is high, and it is low in the next cycle.
- R5: A run executes `cfg_icount` intervals, but never goes past the last interval of the segment (index 124 of 125). A count of 0 means "run to the end of the segment". `cur_interval` never exceeds 125.
- R6: With `cfg_restart`=1 the run begins at interval 0, and a passing run leaves `cur_interval` equal to the number of intervals executed.
- R7: With `cfg_restart`=0 the run begins at the value in `cur_interval`, which is the next interval after the last one completed. If that value is 125 (segment finished), the run begins at 0.
- R8: `cur_interval` advances by one for each passing interval and holds its value between runs.
- R9: Every run ends with `cpu_rst_req` high for exactly one cycle, on pass, on fail and on timeout. `st_done` is set in that same cycle.
- R10: If an interval returns a signature that differs from the expected value, the run ends at that interval with `st_fail` set, and `cur_interval` stays at the index of the failing interval.
- R11: A 32-bit timeout is loaded from `cfg_timeout` at start and counts down once per clock. If it reaches zero before the run completes, the run ends with `st_timeout` set, and intervals not yet finished do not advance `cur_interval`.
- R12: `st_done`, `st_fail` and `st_timeout` are sticky. They are cleared only by a one-cycle `stat_clr` pulse, and later runs only add flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| key_we | input | 1 | Write strobe for the enable key |
| key_val | input | 4 | Enable key value; 4'hA starts a run |
| cfg_icount | input | 8 | Intervals per invocation; 0 = to end of segment |
| cfg_restart | input | 1 | 1 = start at interval 0, 0 = resume |
| cfg_div | input | 4 | Test clock divide value minus one; 0 invalid |
| cfg_timeout | input | 32 | Timeout load value in clock cycles |
| stat_clr | input | 1 | Clears the three status flags |
| flt_en | input | 1 | Stub engine fault hook enable |
| flt_idx | input | 7 | Interval index that returns a bad signature |
| stall | output | 1 | Host is halted while high |
| cpu_rst_req | output | 1 | One-cycle CPU reset request at run end |
| cur_interval | output | 7 | Next interval to run (continuation point) |
| st_done | output | 1 | Sticky: a run has completed |
| st_fail | output | 1 | Sticky: a signature mismatch occurred |
| st_timeout | output | 1 | Sticky: a run ended by timeout |

## Verification
A wrong continuation point in the sequencer shows up in `cur_interval` once the next run has finished, and it is also visible in the run length, because the run stops at the segment end earlier or later than predicted. A broken step or mismatch path shows at the ports within one run: the final counter value, the fail flag and the single reset pulse all differ from what an independent model of start point, count and fault index predicts. A faulty stall or reset-request window is caught in the very cycle after the end of the run.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

    localparam int SEG_INTERVALS = 125;
    localparam logic [3:0] GO_KEY = 4'hA;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_WAIT,
        SQ_END
    } seq_state_t;

    typedef struct packed {
        logic done;
        logic fail;
        logic tmo;
    } run_stat_t;

    // Golden signature of one interval, shared by the stub engine and the comparator.
    function automatic logic [31:0] golden_sig(input int unsigned idx);
        logic [31:0] h;
        h = idx * 32'h9E37_79B1;
        h = h ^ (h >> 15) ^ 32'h5A3C_0F11;
        return h;
    endfunction

endpackage

// File: rtl/lbist_clkdiv.sv
module lbist_clkdiv #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (cnt == div) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = en && (cnt == div);
endmodule

// File: rtl/lbist_tmo.sv
module lbist_tmo #(
    parameter int TMO_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [TMO_W-1:0] load_val,
    input  logic             run,
    output logic             expired
);
    logic [TMO_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = run && (cnt == '0);
endmodule

// File: rtl/lbist_iv_engine.sv
module lbist_iv_engine
    import lbist_pkg::*;
#(
    parameter int IDX_W = 7,
    parameter int TICKS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             abort,
    input  logic [IDX_W-1:0] idx,
    input  logic             tick,
    input  logic             flt_en,
    input  logic [IDX_W-1:0] flt_idx,
    output logic             busy,
    output logic             done,
    output logic [31:0]      sig
);
    localparam int TC_W = $clog2(TICKS + 1);

    logic [IDX_W-1:0] idx_q;
    logic [TC_W-1:0]  tcnt;
    logic             hit;

    assign hit = flt_en && (flt_idx == idx_q);

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            idx_q <= '0;
            tcnt  <= '0;
            sig   <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy  <= 1'b1;
                idx_q <= idx;
                tcnt  <= '0;
            end else if (busy && tick) begin
                if (tcnt == TC_W'(TICKS - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    sig  <= golden_sig(int'(idx_q)) ^ {31'd0, hit};
                end else begin
                    tcnt <= tcnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/lbist_seq.sv
module lbist_seq
    import lbist_pkg::*;
#(
    parameter int NUM_IV = SEG_INTERVALS,
    parameter int CNT_W  = 8,
    parameter int DIV_W  = 4,
    parameter int TMO_W  = 32,
    parameter int TICKS  = 4,
    localparam int IDX_W = $clog2(NUM_IV + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             key_we,
    input  logic [3:0]       key_val,
    input  logic [CNT_W-1:0] cfg_icount,
    input  logic             cfg_restart,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [TMO_W-1:0] cfg_timeout,
    input  logic             stat_clr,
    input  logic             flt_en,
    input  logic [IDX_W-1:0] flt_idx,
    output logic             stall,
    output logic             cpu_rst_req,
    output logic [IDX_W-1:0] cur_interval,
    output logic             st_done,
    output logic             st_fail,
    output logic             st_timeout
);
    localparam int REM_W = (CNT_W > IDX_W) ? CNT_W : IDX_W;

    seq_state_t       state;
    run_stat_t        stat;
    logic [IDX_W-1:0] cur;
    logic [REM_W-1:0] rem;
    logic [DIV_W-1:0] div_q;
    logic             go;
    logic [IDX_W-1:0] start_idx;
    logic [REM_W-1:0] start_rem;
    logic             eng_start, eng_abort, eng_busy, eng_done, tick;
    logic [31:0]      eng_sig;
    logic             tmo_hit, running, last_iv, sig_ok;

    assign go      = (state == SQ_IDLE) && key_we && (key_val == GO_KEY) && (cfg_div != '0);
    assign running = (state == SQ_ISSUE) || (state == SQ_WAIT);

    always_comb begin
        if (cfg_restart || int'(cur) >= NUM_IV) begin
            start_idx = '0;
        end else begin
            start_idx = cur;
        end
        if (cfg_icount == '0) begin
            start_rem = REM_W'(NUM_IV - int'(start_idx));
        end else begin
            start_rem = REM_W'(cfg_icount);
        end
    end

    assign last_iv   = (rem == REM_W'(1)) || (int'(cur) + 1 >= NUM_IV);
    assign sig_ok    = (eng_sig == golden_sig(int'(cur)));
    assign eng_start = (state == SQ_ISSUE) && !tmo_hit;
    assign eng_abort = running && tmo_hit;

    lbist_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk (clk),
        .rst (rst),
        .en  (eng_busy),
        .div (div_q),
        .tick(tick)
    );

    lbist_tmo #(.TMO_W(TMO_W)) u_tmo (
        .clk     (clk),
        .rst     (rst),
        .load    (go),
        .load_val(cfg_timeout),
        .run     (running),
        .expired (tmo_hit)
    );

    lbist_iv_engine #(.IDX_W(IDX_W), .TICKS(TICKS)) u_eng (
        .clk    (clk),
        .rst    (rst),
        .start  (eng_start),
        .abort  (eng_abort),
        .idx    (cur),
        .tick   (tick),
        .flt_en (flt_en),
        .flt_idx(flt_idx),
        .busy   (eng_busy),
        .done   (eng_done),
        .sig    (eng_sig)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            stat  <= '0;
            cur   <= '0;
            rem   <= '0;
            div_q <= '0;
        end else begin
            if (stat_clr) begin
                stat <= '0;
            end
            unique case (state)
                SQ_IDLE: begin
                    if (go) begin
                        cur   <= start_idx;
                        rem   <= start_rem;
                        div_q <= cfg_div;
                        state <= SQ_ISSUE;
                    end
                end
                SQ_ISSUE: begin
                    if (tmo_hit) begin
                        stat.tmo  <= 1'b1;
                        stat.done <= 1'b1;
                        state     <= SQ_END;
                    end else begin
                        state <= SQ_WAIT;
                    end
                end
                SQ_WAIT: begin
                    if (tmo_hit) begin
                        stat.tmo  <= 1'b1;
                        stat.done <= 1'b1;
                        state     <= SQ_END;
                    end else if (eng_done) begin
                        if (!sig_ok) begin
                            stat.fail <= 1'b1;
                            stat.done <= 1'b1;
                            state     <= SQ_END;
                        end else begin
                            cur <= cur + 1'b1;
                            rem <= rem - 1'b1;
                            if (last_iv) begin
                                stat.done <= 1'b1;
                                state     <= SQ_END;
                            end else begin
                                state <= SQ_ISSUE;
                            end
                        end
                    end
                end
                SQ_END: begin
                    state <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign stall        = (state != SQ_IDLE);
    assign cpu_rst_req  = (state == SQ_END);
    assign cur_interval = cur;
    assign st_done      = stat.done;
    assign st_fail      = stat.fail;
    assign st_timeout   = stat.tmo;
endmodule

// File: rtl/lbist_seq_chk.sv
module lbist_seq_chk #(
    parameter int NUM_IV = 125,
    parameter int DIV_W  = 4,
    parameter int IDX_W  = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             key_we,
    input logic [DIV_W-1:0] cfg_div,
    input logic             stat_clr,
    input logic             stall,
    input logic             cpu_rst_req,
    input logic [IDX_W-1:0] cur_interval,
    input logic             st_done,
    input logic             st_fail,
    input logic             st_timeout
);
    AST_REQ_ONLY_IN_RUN: assert property (@(posedge clk) disable iff (rst)
        cpu_rst_req |-> stall); // R9

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        cpu_rst_req |=> !cpu_rst_req); // R9

    AST_STALL_DROPS_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        cpu_rst_req |=> !stall); // R4

    AST_STALL_ENDS_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
        (stall && !cpu_rst_req) |=> stall); // R4

    AST_CUR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(cur_interval) <= NUM_IV); // R5

    AST_CUR_HELD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!stall && !key_we) |=> $stable(cur_interval)); // R8

    AST_BAD_DIV_NO_RUN: assert property (@(posedge clk) disable iff (rst)
        (!stall && cfg_div == '0) |=> !stall); // R3

    AST_DONE_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(st_done) |-> cpu_rst_req); // R9

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (st_done && !stat_clr) |=> st_done); // R12

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
        (st_fail && !stat_clr) |=> st_fail); // R12

    AST_TMO_STICKY: assert property (@(posedge clk) disable iff (rst)
        (st_timeout && !stat_clr) |=> st_timeout); // R12
endmodule

bind lbist_seq lbist_seq_chk #(
    .NUM_IV(NUM_IV),
    .DIV_W (DIV_W),
    .IDX_W (IDX_W)
) u_seq_chk (
    .clk         (clk),
    .rst         (rst),
    .key_we      (key_we),
    .cfg_div     (cfg_div),
    .stat_clr    (stat_clr),
    .stall       (stall),
    .cpu_rst_req (cpu_rst_req),
    .cur_interval(cur_interval),
    .st_done     (st_done),
    .st_fail     (st_fail),
    .st_timeout  (st_timeout)
);

// File: tb/test_lbist_seq.sv
module test_lbist_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NIV = 125;
    localparam int RUN_LIMIT = 20000;

    logic        clk = 1'b0;
    logic        rst;
    logic        key_we;
    logic [3:0]  key_val;
    logic [7:0]  cfg_icount;
    logic        cfg_restart;
    logic [3:0]  cfg_div;
    logic [31:0] cfg_timeout;
    logic        stat_clr;
    logic        flt_en;
    logic [6:0]  flt_idx;
    logic        stall, cpu_rst_req, st_done, st_fail, st_timeout;
    logic [6:0]  cur_interval;

    int n_chk = 0;
    int n_bad = 0;
    int m_cur = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lbist_seq i_lbist_seq (
        .clk(clk), .rst(rst), .key_we(key_we), .key_val(key_val),
        .cfg_icount(cfg_icount), .cfg_restart(cfg_restart), .cfg_div(cfg_div),
        .cfg_timeout(cfg_timeout), .stat_clr(stat_clr), .flt_en(flt_en),
        .flt_idx(flt_idx), .stall(stall), .cpu_rst_req(cpu_rst_req),
        .cur_interval(cur_interval), .st_done(st_done), .st_fail(st_fail),
        .st_timeout(st_timeout)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int start_of(input bit rs, input int cur);
        return (rs || cur >= NIV) ? 0 : cur;
    endfunction

    function automatic int len_of(input int st, input int cnt);
        int left = NIV - st;
        return (cnt == 0 || cnt > left) ? left : cnt;
    endfunction

    task automatic clear_status();
        stat_clr = 1'b1;
        @(negedge clk);
        stat_clr = 1'b0;
    endtask

    // Launch one run and follow it to its end; returns what was seen at the ports.
    task automatic launch(input int cnt, input bit rs, input int dv, input logic [31:0] tmo,
                          input bit fe, input int fi, input logic [3:0] key,
                          output bit stall_after, output int reqs, output bit low_after);
        int cyc = 0;
        cfg_icount = 8'(cnt); cfg_restart = rs; cfg_div = 4'(dv); cfg_timeout = tmo;
        flt_en = fe; flt_idx = 7'(fi); key_val = key; key_we = 1'b1;
        @(negedge clk);
        key_we = 1'b0;
        stall_after = stall;
        reqs = 0;
        while (stall && cyc < RUN_LIMIT) begin
            if (cpu_rst_req) reqs++;
            if (cyc == 2) begin key_we = 1'b1; key_val = 4'hA; end
            if (cyc == 3) key_we = 1'b0;
            @(negedge clk);
            cyc++;
        end
        key_we = 1'b0;
        low_after = !stall;
    endtask

    // Passing or failing run with prediction from the model.
    task automatic model_run(input int cnt, input bit rs, input int dv, input bit fe,
                             input int fi, input string tag);
        bit sa, la; int rq; int st, n, exp_cur; bit exp_fail;
        st = start_of(rs, m_cur);
        n = len_of(st, cnt);
        exp_fail = fe && fi >= st && fi < st + n;
        exp_cur = exp_fail ? fi : st + n;
        clear_status();
        launch(cnt, rs, dv, 32'hFFFF_FFFF, fe, fi, 4'hA, sa, rq, la);
        chk(sa == 1'b1, {tag, " R4 stall"}, int'(sa), 1);
        chk(rq == 1 && la, {tag, " R9 one request"}, rq, 1);
        chk(int'(cur_interval) == exp_cur, {tag, " R5 cur"}, int'(cur_interval), exp_cur);
        chk(st_done && st_fail == exp_fail && !st_timeout, {tag, " R10 status"},
            int'({st_done, st_fail, st_timeout}), int'({1'b1, exp_fail, 1'b0}));
        m_cur = exp_cur;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        bit sa, la; int rq;
        void'($urandom(32'd1357));
        rst = 1'b1; key_we = 0; key_val = 0; cfg_icount = 0; cfg_restart = 0;
        cfg_div = 4'd2; cfg_timeout = '1; stat_clr = 0; flt_en = 0; flt_idx = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(!stall && !cpu_rst_req && cur_interval == 0 && !st_done && !st_fail && !st_timeout,
            "R1 reset", int'({stall, cpu_rst_req, st_done, st_fail, st_timeout}), 0);

        // R2: wrong key
        launch(3, 1, 2, '1, 0, 0, 4'h5, sa, rq, la);
        repeat (4) @(negedge clk);
        chk(!sa && !stall && rq == 0 && cur_interval == 0 && !st_done, "R2 wrong key",
            int'({sa, stall}), 0);

        // R3: divide by one rejected
        launch(3, 1, 0, '1, 0, 0, 4'hA, sa, rq, la);
        chk(!sa && cur_interval == 0 && !st_done, "R3 div zero", int'(sa), 0);

        // R6 restart, then R7/R8 continuation
        model_run(3, 1, 1, 0, 0, "R6 restart");
        chk(int'(cur_interval) == 3, "R6 cur after restart", int'(cur_interval), 3);
        model_run(2, 0, 3, 0, 0, "R7 continue");
        chk(int'(cur_interval) == 5, "R8 cur persists", int'(cur_interval), 5);
        // R5: count 0 runs to segment end
        model_run(0, 0, 1, 0, 0, "R5 to end");
        chk(int'(cur_interval) == NIV, "R5 end of segment", int'(cur_interval), NIV);
        // R7: finished segment wraps to 0
        model_run(1, 0, 1, 0, 0, "R7 wrap");
        chk(int'(cur_interval) == 1, "R7 wrap cur", int'(cur_interval), 1);
        // R5: count larger than remaining stops at the end
        model_run(200, 0, 1, 0, 0, "R5 clamp");
        // R10: fault at an interval
        model_run(10, 1, 1, 1, 6, "R10 fault");
        chk(int'(cur_interval) == 6 && st_fail, "R10 stops at failing", int'(cur_interval), 6);

        // R11: timeout
        clear_status();
        launch(5, 0, 3, 32'd3, 0, 0, 4'hA, sa, rq, la);
        chk(st_timeout && st_done && !st_fail, "R11 timeout flag",
            int'({st_done, st_fail, st_timeout}), 5);
        chk(int'(cur_interval) == 6 && rq == 1, "R11 cur unchanged", int'(cur_interval), 6);

        // R12: sticky until clear
        repeat (10) @(negedge clk);
        chk(st_timeout && st_done, "R12 sticky", int'({st_done, st_timeout}), 3);
        clear_status();
        chk(!st_done && !st_fail && !st_timeout, "R12 cleared",
            int'({st_done, st_fail, st_timeout}), 0);

        // Random runs
        for (int i = 0; i < 30; i++) begin
            int cnt = int'($urandom_range(0, 24));
            bit rs = 1'($urandom_range(0, 1));
            int dv = int'($urandom_range(1, 3));
            bit fe = ($urandom_range(0, 3) == 0);
            int fi = int'($urandom_range(0, NIV - 1));
            model_run(cnt, rs, dv, fe, fi, "R5 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule